// File: doc/BRIEF.md
# Sector Group Write Guard

This block decides whether a program or erase request may proceed on a byte-wide flash array of 1M locations. The array is divided into 64 KB sectors. Pairs of adjacent sectors form protection groups, and the block stores one lock bit for each group. Each request gets a registered allow/deny answer. With that answer comes a mask of the sectors that may actually be written or erased.

A multi-sector erase carries a sector selection mask. The guard removes every selected sector that sits in a locked group. If nothing is left, the request is refused.

While a level-held override input is high, every group is treated as unlocked. The stored lock bits are left untouched, so the earlier protection returns as soon as the override drops. A query port reads back the lock state of a sector's group as a status byte. A small synchronous load port sets or clears individual lock bits. That port is ignored while the surrounding controller reports an operation in progress.

Top module: `sector_guard`

## Requirements
- R1: The sector index is address bits 19..16 and the group index is address bits 19..17, so sectors 2k and 2k+1 form group k. An allowed single-sector request returns a mask with only the bit of its sector index set.
- R2: A single-sector request (program or erase alike) into a locked group returns rsp_allow=0 and an all-zero rsp_keep.
- R3: While unlock_hold is 1, requests are judged as though every group were unlocked.
- R4: Dropping unlock_hold restores the earlier protection. The stored lock bits do not change while it is held, and the query port keeps reporting them.
- R5: After reset every group is unlocked.
- R6: A query at address A returns, one cycle later with qry_ack=1, the byte 8'h01 if the group of A is locked and 8'h00 if it is not. It reports the stored bit whatever the state of unlock_hold.
- R7: A multi-sector erase (chk_multi=1, bit i of chk_sel selects sector i) returns rsp_keep = chk_sel with every sector of a locked group cleared. rsp_allow is 0 when that result is all zero, including when nothing was selected.
- R8: A load (ld_en=1) writes ld_set into the lock bit of group ld_group, with the effect visible from the next cycle. A load is ignored while busy=1.
- R9: Every response appears on the cycle after chk_valid, with rsp_valid=1. In a cycle that follows no request, rsp_valid, rsp_allow and rsp_keep are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chk_valid | input | 1 | Request strobe |
| chk_multi | input | 1 | 1: multi-sector erase using chk_sel; 0: single sector from chk_addr |
| chk_addr | input | 20 | Byte address of a single-sector request |
| chk_sel | input | 16 | Sector selection mask for a multi-sector erase |
| unlock_hold | input | 1 | Level-held override that unlocks every group |
| busy | input | 1 | An operation is in progress; loads are ignored |
| ld_en | input | 1 | Load strobe for one lock bit |
| ld_group | input | 3 | Group index to load |
| ld_set | input | 1 | Value to store (1 locks) |
| qry_valid | input | 1 | Status query strobe |
| qry_addr | input | 20 | Address whose group is queried |
| rsp_valid | output | 1 | Response strobe |
| rsp_allow | output | 1 | At least one sector may proceed |
| rsp_keep | output | 16 | Sectors that may proceed |
| qry_ack | output | 1 | Query result strobe |
| qry_data | output | 8 | 8'h01 locked, 8'h00 unlocked |

## Verification
The assertions assume that reset is held for at least one clock edge before any strobe is used, and that chk_sel has meaning only when chk_multi is 1. The bench drives every input on the falling edge. It releases reset only after several edges, and it issues only one kind of strobe at a time, so request, load and query cycles never overlap. This keeps the stability checks on the lock bits meaningful. Loads are issued with busy low, except in the deliberate test where busy is high.

// File: rtl/sg_pkg.sv
package sg_pkg;
  localparam int SG_ADDR_W = 20;
  localparam int SG_SECT_W = 4;
  localparam int SG_GRP_W  = 3;

  typedef enum logic [7:0] {
    QRY_OPEN   = 8'h00,
    QRY_LOCKED = 8'h01
  } qry_code_e;
endpackage

// File: rtl/sg_lock_bits.sv
module sg_lock_bits #(
  parameter int GRP_W = 3,
  localparam int GROUPS = 1 << GRP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy,
  input  logic              ld_en,
  input  logic [GRP_W-1:0]  ld_group,
  input  logic              ld_set,
  output logic [GROUPS-1:0] lock_q
);
  for (genvar g = 0; g < GROUPS; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)
        lock_q[g] <= 1'b0;
      else if (ld_en && !busy && (ld_group == GRP_W'(g)))
        lock_q[g] <= ld_set;
    end
  end
endmodule

// File: rtl/sg_sector_map.sv
module sg_sector_map #(
  parameter int SECT_W = 4,
  parameter int GRP_W  = 3,
  localparam int SECTS  = 1 << SECT_W,
  localparam int GROUPS = 1 << GRP_W,
  localparam int PER_GRP = SECTS / GROUPS
) (
  input  logic [GROUPS-1:0] lock_q,
  input  logic              unlock_hold,
  output logic [SECTS-1:0]  sect_lock
);
  for (genvar s = 0; s < SECTS; s++) begin : g_sect
    assign sect_lock[s] = lock_q[s / PER_GRP] & ~unlock_hold;
  end
endmodule

// File: rtl/sg_decide.sv
module sg_decide #(
  parameter int SECT_W = 4,
  localparam int SECTS = 1 << SECT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chk_valid,
  input  logic              chk_multi,
  input  logic [SECT_W-1:0] chk_sector,
  input  logic [SECTS-1:0]  chk_sel,
  input  logic [SECTS-1:0]  sect_lock,
  output logic              rsp_valid,
  output logic              rsp_allow,
  output logic [SECTS-1:0]  rsp_keep
);
  logic [SECTS-1:0] want;
  logic [SECTS-1:0] keep_d;

  always_comb begin
    want = chk_multi ? chk_sel : (SECTS'(1) << chk_sector);
    keep_d = want & ~sect_lock;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_allow <= 1'b0;
      rsp_keep  <= '0;
    end else begin
      rsp_valid <= chk_valid;
      rsp_allow <= chk_valid && (keep_d != '0);
      rsp_keep  <= chk_valid ? keep_d : '0;
    end
  end
endmodule

// File: rtl/sg_query.sv
module sg_query #(
  parameter int GRP_W = 3,
  localparam int GROUPS = 1 << GRP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              qry_valid,
  input  logic [GRP_W-1:0]  qry_group,
  input  logic [GROUPS-1:0] lock_q,
  output logic              qry_ack,
  output logic [7:0]        qry_data
);
  import sg_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      qry_ack  <= 1'b0;
      qry_data <= 8'h00;
    end else begin
      qry_ack <= qry_valid;
      if (qry_valid)
        qry_data <= lock_q[qry_group] ? 8'(QRY_LOCKED) : 8'(QRY_OPEN);
    end
  end
endmodule

// File: rtl/sector_guard.sv
module sector_guard #(
  parameter int ADDR_W = sg_pkg::SG_ADDR_W,
  parameter int SECT_W = sg_pkg::SG_SECT_W,
  parameter int GRP_W  = sg_pkg::SG_GRP_W,
  localparam int SECTS  = 1 << SECT_W,
  localparam int GROUPS = 1 << GRP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chk_valid,
  input  logic              chk_multi,
  input  logic [ADDR_W-1:0] chk_addr,
  input  logic [SECTS-1:0]  chk_sel,
  input  logic              unlock_hold,
  input  logic              busy,
  input  logic              ld_en,
  input  logic [GRP_W-1:0]  ld_group,
  input  logic              ld_set,
  input  logic              qry_valid,
  input  logic [ADDR_W-1:0] qry_addr,
  output logic              rsp_valid,
  output logic              rsp_allow,
  output logic [SECTS-1:0]  rsp_keep,
  output logic              qry_ack,
  output logic [7:0]        qry_data
);
  logic [GROUPS-1:0] lock_q;
  logic [SECTS-1:0]  sect_lock;
  logic [SECT_W-1:0] chk_sector;
  logic [GRP_W-1:0]  qry_group;
  logic              unused_low;

  assign chk_sector = chk_addr[ADDR_W-1 -: SECT_W];
  assign qry_group  = qry_addr[ADDR_W-1 -: GRP_W];
  assign unused_low = ^{chk_addr[ADDR_W-SECT_W-1:0], qry_addr[ADDR_W-GRP_W-1:0]};

  sg_lock_bits #(.GRP_W(GRP_W)) bits_i (
    .clk(clk), .rst(rst), .busy(busy), .ld_en(ld_en),
    .ld_group(ld_group), .ld_set(ld_set), .lock_q(lock_q)
  );

  sg_sector_map #(.SECT_W(SECT_W), .GRP_W(GRP_W)) map_i (
    .lock_q(lock_q), .unlock_hold(unlock_hold), .sect_lock(sect_lock)
  );

  sg_decide #(.SECT_W(SECT_W)) dec_i (
    .clk(clk), .rst(rst), .chk_valid(chk_valid), .chk_multi(chk_multi),
    .chk_sector(chk_sector), .chk_sel(chk_sel), .sect_lock(sect_lock),
    .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .rsp_keep(rsp_keep)
  );

  sg_query #(.GRP_W(GRP_W)) qry_i (
    .clk(clk), .rst(rst), .qry_valid(qry_valid), .qry_group(qry_group),
    .lock_q(lock_q), .qry_ack(qry_ack), .qry_data(qry_data)
  );
endmodule

// File: rtl/sg_guard_chk.sv
module sg_guard_chk #(
  parameter int SECTS  = 16,
  parameter int GROUPS = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              chk_valid,
  input logic              chk_multi,
  input logic [SECTS-1:0]  chk_sel,
  input logic              unlock_hold,
  input logic              busy,
  input logic              ld_en,
  input logic              qry_valid,
  input logic              rsp_valid,
  input logic              rsp_allow,
  input logic [SECTS-1:0]  rsp_keep,
  input logic              qry_ack,
  input logic [7:0]        qry_data,
  input logic [GROUPS-1:0] lock_q
);
  assert_rsp_follows_R9: assert property (@(posedge clk) disable iff (rst)
    chk_valid |=> rsp_valid);
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !chk_valid |=> (!rsp_valid && !rsp_allow && rsp_keep == '0));
  assert_single_onehot_R1: assert property (@(posedge clk) disable iff (rst)
    (chk_valid && !chk_multi) |=> $onehot0(rsp_keep));
  assert_hold_opens_R3: assert property (@(posedge clk) disable iff (rst)
    (chk_valid && !chk_multi && unlock_hold) |=> rsp_allow);
  assert_hold_multi_R7: assert property (@(posedge clk) disable iff (rst)
    (chk_valid && chk_multi && unlock_hold) |=> (rsp_keep == $past(chk_sel)));
  assert_busy_freeze_R8: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(lock_q));
  assert_hold_keeps_bits_R4: assert property (@(posedge clk) disable iff (rst)
    (unlock_hold && !ld_en) |=> $stable(lock_q));
  assert_reset_clear_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (lock_q == '0));
  assert_query_ack_R6: assert property (@(posedge clk) disable iff (rst)
    qry_valid |=> qry_ack);
  assert_query_code_R6: assert property (@(posedge clk) disable iff (rst)
    qry_ack |-> (qry_data == 8'h00 || qry_data == 8'h01));
endmodule

bind sector_guard sg_guard_chk #(.SECTS(SECTS), .GROUPS(GROUPS)) chk_i (
  .clk(clk), .rst(rst), .chk_valid(chk_valid), .chk_multi(chk_multi),
  .chk_sel(chk_sel), .unlock_hold(unlock_hold), .busy(busy), .ld_en(ld_en),
  .qry_valid(qry_valid), .rsp_valid(rsp_valid), .rsp_allow(rsp_allow),
  .rsp_keep(rsp_keep), .qry_ack(qry_ack), .qry_data(qry_data), .lock_q(lock_q)
);

// File: tb/sector_guard_tb_top.sv
module sector_guard_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic chk_valid = 0, chk_multi = 0, unlock_hold = 0, busy = 0;
  logic ld_en = 0, ld_set = 0, qry_valid = 0;
  logic [19:0] chk_addr = '0, qry_addr = '0;
  logic [15:0] chk_sel = '0;
  logic [2:0]  ld_group = '0;
  logic rsp_valid, rsp_allow, qry_ack;
  logic [15:0] rsp_keep;
  logic [7:0]  qry_data;

  int checks = 0;
  int errors = 0;
  logic [7:0] locks;

  always #5 clk = ~clk;

  sector_guard dut_i (
    .clk(clk), .rst(rst), .chk_valid(chk_valid), .chk_multi(chk_multi),
    .chk_addr(chk_addr), .chk_sel(chk_sel), .unlock_hold(unlock_hold),
    .busy(busy), .ld_en(ld_en), .ld_group(ld_group), .ld_set(ld_set),
    .qry_valid(qry_valid), .qry_addr(qry_addr), .rsp_valid(rsp_valid),
    .rsp_allow(rsp_allow), .rsp_keep(rsp_keep), .qry_ack(qry_ack),
    .qry_data(qry_data)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] sect_mask(input logic [7:0] lk, input logic hold);
    logic [15:0] m;
    for (int s = 0; s < 16; s++) m[s] = lk[s / 2] & ~hold;
    return m;
  endfunction

  task automatic load(input int g, input logic v);
    @(negedge clk);
    ld_en = 1; ld_group = 3'(g); ld_set = v;
    @(negedge clk);
    ld_en = 0;
  endtask

  task automatic single(input int s, input logic [15:0] low, input logic [7:0] lk, input logic hold);
    logic [15:0] expk;
    @(negedge clk);
    chk_valid = 1; chk_multi = 0; chk_addr = {4'(s), low}; unlock_hold = hold;
    @(posedge clk); #1;
    expk = (16'(1) << s) & ~sect_mask(lk, hold);
    check(rsp_valid === 1'b1, "R9 rsp_valid", int'(rsp_valid), 1);
    check(rsp_keep === expk, hold ? "R3 single keep" : "R1/R2 single keep",
          int'(rsp_keep), int'(expk));
    check(rsp_allow === (expk != 0), lk[s/2] && !hold ? "R2 deny" : "R1 allow",
          int'(rsp_allow), int'(expk != 0));
    chk_valid = 0;
  endtask

  task automatic multi(input logic [15:0] sel, input logic [7:0] lk, input logic hold);
    logic [15:0] expk;
    @(negedge clk);
    chk_valid = 1; chk_multi = 1; chk_sel = sel; unlock_hold = hold;
    @(posedge clk); #1;
    expk = sel & ~sect_mask(lk, hold);
    check(rsp_keep === expk, "R7 multi keep", int'(rsp_keep), int'(expk));
    check(rsp_allow === (expk != 0), "R7 multi allow", int'(rsp_allow), int'(expk != 0));
    chk_valid = 0; chk_multi = 0;
  endtask

  task automatic query(input int s, input logic [7:0] lk, input logic hold, input string tag);
    logic [7:0] e;
    @(negedge clk);
    qry_valid = 1; qry_addr = {4'(s), 16'h0002}; unlock_hold = hold;
    @(posedge clk); #1;
    e = lk[s / 2] ? 8'h01 : 8'h00;
    check(qry_ack === 1'b1, "R6 ack", int'(qry_ack), 1);
    check(qry_data === e, tag, int'(qry_data), int'(e));
    qry_valid = 0;
  endtask

  initial begin
    fork
      begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 0;
        @(posedge clk); #1;
        check(rsp_valid === 0 && rsp_keep === 0, "R9 idle after reset", int'(rsp_keep), 0);
        for (int s = 0; s < 16; s++) query(s, 8'h00, 0, "R5 reset unlocked");
        for (int s = 0; s < 16; s++) single(s, 16'h1234, 8'h00, 0);
        for (int p = 0; p < 256; p++) begin
          locks = 8'(p);
          for (int g = 0; g < 8; g++) load(g, locks[g]);
          for (int s = 0; s < 16; s++) begin
            single(s, 16'(p * 251 + s), locks, 0);
            query(s, locks, 0, "R6/R8 query");
          end
          multi(16'(p * 97 + 3), locks, 0);
          multi(16'hFFFF, locks, 0);
          multi(16'h0000, locks, 0);
          if (p % 16 == 5) begin
            for (int s = 0; s < 16; s++) single(s, 16'hFFFF, locks, 1);
            multi(16'hA5C3, locks, 1);
            query(3, locks, 1, "R4 query during hold");
            for (int s = 0; s < 16; s++) single(s, 16'h0000, locks, 0);
          end
        end
        locks = 8'h3C;
        for (int g = 0; g < 8; g++) load(g, locks[g]);
        @(negedge clk) busy = 1;
        for (int g = 0; g < 8; g++) load(g, ~locks[g]);
        @(negedge clk) busy = 0;
        for (int s = 0; s < 16; s++) query(s, locks, 0, "R8 busy load ignored");
        for (int s = 0; s < 16; s++) single(s, 16'h00AA, locks, 0);
      end
      begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule